// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Fetch Sequencer

This block generates the address and burst control for the read side of a display DMA engine. It walks a frame buffer in memory from a base byte address up to an inclusive ceiling byte address. It issues one read burst at a time and steers the returned words to a pixel FIFO or to a palette store. With dual mode on, it alternates between two buffer descriptors and raises a separate end-of-frame flag for each. With dual mode off, it fetches buffer 0 over and over.

A load-mode input adds a palette phase that reads the buffer 0 range into the palette store. It can run before pixel fetching or on its own. The block also keeps a small write-1-to-clear status vector and an interrupt line. The status vector holds end of frame per buffer, palette load done, FIFO underflow and sync lost.

Words are 2^WB_LG bytes wide. Descriptor inputs are sampled only when fetching of that buffer begins.

Top module: `fb_fetch_seq`

## Requirements
- R1: Burst code 0,1,2,3,4 selects a nominal burst of 1,2,4,8,16 words. Codes 5 to 7 are invalid, and while one is applied no request is issued.
- R2: A burst is shortened to the words left before the inclusive ceiling, so no byte above the ceiling is ever requested. Successive requests advance by length times 4 bytes.
- R3: While req_o is high, req_ready_i is low and the raster stays enabled, req_o stays high in the next cycle with the same address.
- R4: With dual mode off, buffer 0 is fetched repeatedly from its base. Status bit 8 is set after its last word, and bit 9 stays clear.
- R5: With dual mode on, buffer 0 and buffer 1 are fetched in turn, starting with buffer 0. The end of buffer 0 sets status bit 8 and the end of buffer 1 sets status bit 9.
- R6: A buffer's base and ceiling are sampled when fetching of that buffer begins. A change made during the fetch takes effect on the next fetch of that buffer.
- R7: Load mode 2 fetches pixel data only. Load mode 0 first reads the buffer 0 range to the palette strobe, sets status bit 6, and then fetches pixel data from buffer 0. Load mode 3 issues no request.
- R8: Load mode 1 reads the buffer 0 range to the palette strobe only and sets status bit 6. The read repeats each time bit 6 is cleared while the raster is still enabled, and does not repeat once the raster is off.
- R9: A pixel read while the FIFO is empty and the raster is enabled sets status bit 5. The same event with the raster off has no effect.
- R10: A high on sync_lost_i sets status bit 2.
- R11: A 1 in stat_clr_i clears that status bit on the next edge. A set event in the same cycle wins over the clear.
- R12: irq_o is high exactly when the end-of-frame interrupt enable is high and status bit 8 or bit 9 is set.
- R13: When the raster is disabled, a burst already accepted still completes, and no new request follows.
- R14: After reset, req_o, both write strobes, irq_o and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raster_en_i | input | 1 | Raster running; starts and sustains fetching |
| dual_en_i | input | 1 | Alternate between buffer 0 and buffer 1 |
| eof_irq_en_i | input | 1 | End-of-frame interrupt enable |
| burst_code_i | input | 3 | Burst length code |
| load_mode_i | input | 2 | 0 palette+data, 1 palette only, 2 data only |
| base0_i | input | AW | Buffer 0 base byte address |
| ceil0_i | input | AW | Buffer 0 inclusive ceiling byte address |
| base1_i | input | AW | Buffer 1 base byte address |
| ceil1_i | input | AW | Buffer 1 inclusive ceiling byte address |
| req_o | output | 1 | Burst request |
| req_addr_o | output | AW | Burst start byte address |
| req_len_o | output | LEN_W | Burst length in words |
| req_ready_i | input | 1 | Request accepted this cycle |
| rd_valid_i | input | 1 | Read data word valid |
| rd_data_i | input | DW | Read data word |
| wr_data_o | output | DW | Data toward FIFO or palette store |
| fifo_wr_o | output | 1 | Pixel FIFO write strobe |
| pal_wr_o | output | 1 | Palette store write strobe |
| pix_rd_i | input | 1 | Pixel side reads the FIFO |
| fifo_empty_i | input | 1 | Pixel FIFO is empty |
| sync_lost_i | input | 1 | Sync loss event |
| stat_clr_i | input | 10 | Write-1-to-clear mask for the status bits |
| stat_o | output | 10 | Status: 9 eof1, 8 eof0, 6 palette done, 5 underflow, 2 sync lost |
| irq_o | output | 1 | End-of-frame interrupt |

## Verification
The first request appears one cycle after the raster enable is seen. After the last beat of a burst, the next request is up one cycle later. A status flag is set on the edge that takes its event, which is the edge of the last beat for frame and palette flags. A clear takes effect on the edge that takes the clear mask. The bench drives inputs 2 ns after a rising edge, and its memory model answers on the falling edge. Outputs are sampled 1 ns before the next rising edge, so every check reads a value that has settled for at least one edge. Sequences of requests are compared against address and length lists worked out from the base, ceiling and burst code.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [1:0] {
    LM_PAL_DATA  = 2'd0,
    LM_PAL_ONLY  = 2'd1,
    LM_DATA_ONLY = 2'd2,
    LM_RSVD      = 2'd3
  } load_mode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_BEAT,
    S_PWAIT
  } seq_state_e;

  localparam int STAT_W  = 10;
  localparam int ST_EOF1 = 9;
  localparam int ST_EOF0 = 8;
  localparam int ST_PAL  = 6;
  localparam int ST_UFL  = 5;
  localparam int ST_SYNC = 2;
endpackage

// File: rtl/fbf_burst_calc.sv
module fbf_burst_calc #(
  parameter int AW       = 32,
  parameter int WB_LG    = 2,
  parameter int MAX_CODE = 4,
  localparam int LEN_W   = MAX_CODE + 1
) (
  input  logic [2:0]       code_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [AW-1:0]    ceil_i,
  output logic             code_ok_o,
  output logic [LEN_W-1:0] len_o,
  output logic             last_o
);
  logic [LEN_W-1:0] nominal;
  logic [AW-1:0]    words_left;

  assign code_ok_o  = (code_i <= 3'(MAX_CODE));
  assign nominal    = LEN_W'(1) << code_i;
  // inclusive ceiling: words left = (ceil - addr)/word + 1
  assign words_left = ((ceil_i - addr_i) >> WB_LG) + AW'(1);
  assign last_o     = (words_left <= AW'(nominal));
  assign len_o      = last_o ? words_left[LEN_W-1:0] : nominal;
endmodule

// File: rtl/fbf_status.sv
module fbf_status
  import fbf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        eof_i,
  input  logic              pal_done_i,
  input  logic              ufl_i,
  input  logic              sync_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] set_v, stat_q;

  always_comb begin
    set_v          = '0;
    set_v[ST_EOF0] = eof_i[0];
    set_v[ST_EOF1] = eof_i[1];
    set_v[ST_PAL]  = pal_done_i;
    set_v[ST_UFL]  = ufl_i;
    set_v[ST_SYNC] = sync_i;
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_v;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/fbf_seq_fsm.sv
module fbf_seq_fsm
  import fbf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int WB_LG    = 2,
  parameter int MAX_CODE = 4,
  localparam int LEN_W   = MAX_CODE + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raster_en_i,
  input  logic             dual_en_i,
  input  logic [1:0]       load_mode_i,
  input  logic [AW-1:0]    base0_i,
  input  logic [AW-1:0]    ceil0_i,
  input  logic [AW-1:0]    base1_i,
  input  logic [AW-1:0]    ceil1_i,
  input  logic             code_ok_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             last_i,
  input  logic             req_ready_i,
  input  logic             rd_valid_i,
  input  logic             pal_flag_i,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    ceil_o,
  output logic             req_o,
  output logic             fifo_wr_o,
  output logic             pal_wr_o,
  output logic [1:0]       eof_o,
  output logic             pal_done_o
);
  seq_state_e       state_q, state_d;
  logic [AW-1:0]    addr_q, addr_d, ceil_q, ceil_d;
  logic [LEN_W-1:0] len_q, len_d, beat_q, beat_d;
  logic             last_q, last_d, sel_q, sel_d;
  logic             is_pal_q, is_pal_d, pal_only_q, pal_only_d;
  logic             beat_done, buf_end, nsel;
  load_mode_e       mode;

  assign mode      = load_mode_e'(load_mode_i);
  assign req_o     = (state_q == S_REQ) && code_ok_i;
  assign beat_done = (state_q == S_BEAT) && rd_valid_i && (beat_q == len_q - LEN_W'(1));
  assign buf_end   = beat_done && last_q;
  assign nsel      = dual_en_i && !sel_q;

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    ceil_d     = ceil_q;
    len_d      = len_q;
    beat_d     = beat_q;
    last_d     = last_q;
    sel_d      = sel_q;
    is_pal_d   = is_pal_q;
    pal_only_d = pal_only_q;
    unique case (state_q)
      S_IDLE: begin
        if (raster_en_i && code_ok_i && mode != LM_RSVD) begin
          pal_only_d = (mode == LM_PAL_ONLY);
          is_pal_d   = (mode != LM_DATA_ONLY);
          sel_d      = 1'b0;
          addr_d     = base0_i;
          ceil_d     = ceil0_i;
          state_d    = S_REQ;
        end
      end
      S_REQ: begin
        if (!raster_en_i) begin
          state_d = S_IDLE;
        end else if (req_o && req_ready_i) begin
          len_d   = len_i;
          last_d  = last_i;
          beat_d  = '0;
          state_d = S_BEAT;
        end
      end
      S_BEAT: begin
        if (rd_valid_i) beat_d = beat_q + LEN_W'(1);
        if (beat_done) begin
          addr_d  = addr_q + (AW'(len_q) << WB_LG);
          state_d = raster_en_i ? S_REQ : S_IDLE;
          if (last_q) begin
            if (is_pal_q && pal_only_q) begin
              state_d = S_PWAIT;
            end else begin
              is_pal_d = 1'b0;
              sel_d    = is_pal_q ? 1'b0 : nsel;
              addr_d   = (!is_pal_q && nsel) ? base1_i : base0_i;
              ceil_d   = (!is_pal_q && nsel) ? ceil1_i : ceil0_i;
            end
          end
        end
      end
      S_PWAIT: begin
        if (!raster_en_i) begin
          state_d = S_IDLE;
        end else if (!pal_flag_i) begin
          is_pal_d = 1'b1;
          addr_d   = base0_i;
          ceil_d   = ceil0_i;
          state_d  = S_REQ;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      ceil_q     <= '0;
      len_q      <= '0;
      beat_q     <= '0;
      last_q     <= 1'b0;
      sel_q      <= 1'b0;
      is_pal_q   <= 1'b0;
      pal_only_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      addr_q     <= addr_d;
      ceil_q     <= ceil_d;
      len_q      <= len_d;
      beat_q     <= beat_d;
      last_q     <= last_d;
      sel_q      <= sel_d;
      is_pal_q   <= is_pal_d;
      pal_only_q <= pal_only_d;
    end
  end

  assign addr_o     = addr_q;
  assign ceil_o     = ceil_q;
  assign fifo_wr_o  = (state_q == S_BEAT) && rd_valid_i && !is_pal_q;
  assign pal_wr_o   = (state_q == S_BEAT) && rd_valid_i && is_pal_q;
  assign pal_done_o = buf_end && is_pal_q;
  assign eof_o      = {buf_end && !is_pal_q && sel_q, buf_end && !is_pal_q && !sel_q};
endmodule

// File: rtl/fb_fetch_seq.sv
module fb_fetch_seq
  import fbf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int WB_LG    = 2,
  parameter int MAX_CODE = 4,
  localparam int LEN_W   = MAX_CODE + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raster_en_i,
  input  logic              dual_en_i,
  input  logic              eof_irq_en_i,
  input  logic [2:0]        burst_code_i,
  input  logic [1:0]        load_mode_i,
  input  logic [AW-1:0]     base0_i,
  input  logic [AW-1:0]     ceil0_i,
  input  logic [AW-1:0]     base1_i,
  input  logic [AW-1:0]     ceil1_i,
  output logic              req_o,
  output logic [AW-1:0]     req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  input  logic              req_ready_i,
  input  logic              rd_valid_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic [DW-1:0]     wr_data_o,
  output logic              fifo_wr_o,
  output logic              pal_wr_o,
  input  logic              pix_rd_i,
  input  logic              fifo_empty_i,
  input  logic              sync_lost_i,
  input  logic [STAT_W-1:0] stat_clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [AW-1:0]    cur_addr, cur_ceil;
  logic [LEN_W-1:0] len;
  logic             code_ok, last, pal_done, ufl;
  logic [1:0]       eof;

  fbf_burst_calc #(.AW(AW), .WB_LG(WB_LG), .MAX_CODE(MAX_CODE)) u_calc (
    .code_i    (burst_code_i),
    .addr_i    (cur_addr),
    .ceil_i    (cur_ceil),
    .code_ok_o (code_ok),
    .len_o     (len),
    .last_o    (last)
  );

  fbf_seq_fsm #(.AW(AW), .WB_LG(WB_LG), .MAX_CODE(MAX_CODE)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raster_en_i (raster_en_i),
    .dual_en_i   (dual_en_i),
    .load_mode_i (load_mode_i),
    .base0_i     (base0_i),
    .ceil0_i     (ceil0_i),
    .base1_i     (base1_i),
    .ceil1_i     (ceil1_i),
    .code_ok_i   (code_ok),
    .len_i       (len),
    .last_i      (last),
    .req_ready_i (req_ready_i),
    .rd_valid_i  (rd_valid_i),
    .pal_flag_i  (stat_o[ST_PAL]),
    .addr_o      (cur_addr),
    .ceil_o      (cur_ceil),
    .req_o       (req_o),
    .fifo_wr_o   (fifo_wr_o),
    .pal_wr_o    (pal_wr_o),
    .eof_o       (eof),
    .pal_done_o  (pal_done)
  );

  assign ufl = raster_en_i && pix_rd_i && fifo_empty_i;

  fbf_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eof_i      (eof),
    .pal_done_i (pal_done),
    .ufl_i      (ufl),
    .sync_i     (sync_lost_i),
    .clr_i      (stat_clr_i),
    .stat_o     (stat_o)
  );

  assign req_addr_o = cur_addr;
  assign req_len_o  = len;
  assign wr_data_o  = rd_data_i;
  assign irq_o      = eof_irq_en_i && (stat_o[ST_EOF0] || stat_o[ST_EOF1]);
endmodule

// File: rtl/fbf_checker.sv
module fbf_checker #(
  parameter int AW       = 32,
  parameter int WB_LG    = 2,
  parameter int MAX_CODE = 4,
  parameter int LEN_W    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             raster_en_i,
  input logic [2:0]       burst_code_i,
  input logic             req_o,
  input logic [AW-1:0]    req_addr_o,
  input logic [LEN_W-1:0] req_len_o,
  input logic             req_ready_i,
  input logic             fifo_wr_o,
  input logic             pal_wr_o,
  input logic             pix_rd_i,
  input logic             fifo_empty_i,
  input logic             sync_lost_i,
  input logic [9:0]       stat_o,
  input logic [AW-1:0]    cur_ceil
);
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_len_o != '0) && (req_len_o <= (LEN_W'(1) << burst_code_i))); // R1
  AST_NO_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_code_i > 3'(MAX_CODE)) |-> !req_o); // R1
  AST_CEIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_addr_o + (AW'(req_len_o) << WB_LG) - AW'(1) <= cur_ceil)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !req_ready_i && raster_en_i) |=>
      ($stable(req_addr_o) && (req_o || burst_code_i > 3'(MAX_CODE)))); // R3
  AST_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_wr_o && pal_wr_o)); // R8
  AST_UFL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raster_en_i && pix_rd_i && fifo_empty_i) |=> stat_o[5]); // R9
  AST_SYNC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lost_i |=> stat_o[2]); // R10
endmodule

bind fb_fetch_seq fbf_checker #(
  .AW(AW), .WB_LG(WB_LG), .MAX_CODE(MAX_CODE), .LEN_W(LEN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .raster_en_i  (raster_en_i),
  .burst_code_i (burst_code_i),
  .req_o        (req_o),
  .req_addr_o   (req_addr_o),
  .req_len_o    (req_len_o),
  .req_ready_i  (req_ready_i),
  .fifo_wr_o    (fifo_wr_o),
  .pal_wr_o     (pal_wr_o),
  .pix_rd_i     (pix_rd_i),
  .fifo_empty_i (fifo_empty_i),
  .sync_lost_i  (sync_lost_i),
  .stat_o       (stat_o),
  .cur_ceil     (cur_ceil)
);

// File: tb/fb_fetch_seq_tb_top.sv
module fb_fetch_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raster_en = 1'b0, dual_en = 1'b0, eof_en = 1'b0;
  logic [2:0]  code = 3'd0;
  logic [1:0]  mode = 2'd2;
  logic [31:0] base0 = '0, ceil0 = '0, base1 = '0, ceil1 = '0;
  logic        req;
  logic [31:0] req_addr;
  logic [4:0]  req_len;
  logic        req_ready = 1'b1;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = 32'h0;
  logic [31:0] wr_data;
  logic        fifo_wr, pal_wr;
  logic        pix_rd = 1'b0, fifo_empty = 1'b0, sync_lost = 1'b0;
  logic [9:0]  stat_clr = '0;
  logic [9:0]  stat;
  logic        irq;

  int checks = 0, fails = 0;
  int log_n = 0, beats_left = 0, pal_cnt = 0, fifo_cnt = 0;
  logic [31:0] log_addr [0:63];
  int          log_len  [0:63];

  always #4 clk = ~clk;

  fb_fetch_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .raster_en_i(raster_en), .dual_en_i(dual_en),
    .eof_irq_en_i(eof_en), .burst_code_i(code), .load_mode_i(mode),
    .base0_i(base0), .ceil0_i(ceil0), .base1_i(base1), .ceil1_i(ceil1),
    .req_o(req), .req_addr_o(req_addr), .req_len_o(req_len), .req_ready_i(req_ready),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .wr_data_o(wr_data),
    .fifo_wr_o(fifo_wr), .pal_wr_o(pal_wr), .pix_rd_i(pix_rd), .fifo_empty_i(fifo_empty),
    .sync_lost_i(sync_lost), .stat_clr_i(stat_clr), .stat_o(stat), .irq_o(irq)
  );

  // memory model: answers on the falling edge
  initial forever begin
    @(negedge clk);
    if (beats_left > 0) begin
      rd_valid   = 1'b1;
      rd_data    = rd_data + 32'd1;
      beats_left = beats_left - 1;
    end else begin
      rd_valid = 1'b0;
      if (req && req_ready) begin
        if (log_n < 64) begin
          log_addr[log_n] = req_addr;
          log_len[log_n]  = int'(req_len);
        end
        log_n      = log_n + 1;
        beats_left = int'(req_len);
      end
    end
  end

  // strobe monitor: 1 ns before the rising edge
  initial forever begin
    @(negedge clk);
    #3;
    if (fifo_wr) fifo_cnt = fifo_cnt + 1;
    if (pal_wr)  pal_cnt  = pal_cnt + 1;
  end

  initial begin
    #(8 * 100000);
    fails  = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not finish (act=hung exp=done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", rq, act, exp);
    end
  endtask

  task automatic clr(input logic [9:0] m);
    stat_clr = m;
    tick(1);
    stat_clr = '0;
  endtask

  task automatic wait_log(input int k);
    for (int g = 0; g < 3000 && log_n < k; g++) tick(1);
  endtask

  task automatic fresh();
    raster_en = 1'b0;
    tick(40);
    clr(10'h3FF);
    tick(1);
    log_n = 0; pal_cnt = 0; fifo_cnt = 0;
  endtask

  task automatic t_reset();
    chk(stat == '0, "R14 stat", stat, 0);
    chk(!req && !fifo_wr && !pal_wr, "R14 strobes", {req, fifo_wr, pal_wr}, 0);
    chk(!irq, "R14 irq", irq, 0);
  endtask

  task automatic t_bad_code();
    fresh();
    code = 3'd5; mode = 2'd2; base0 = 32'h100; ceil0 = 32'h10F;
    raster_en = 1'b1;
    tick(20);
    chk(log_n == 0, "R1 invalid code issues nothing", log_n, 0);
    code = 3'd7;
    tick(10);
    chk(log_n == 0, "R1 code 7 issues nothing", log_n, 0);
    code = 3'd2; mode = 2'd3;
    raster_en = 1'b0; tick(2); raster_en = 1'b1;
    tick(20);
    chk(log_n == 0, "R7 mode 3 issues nothing", log_n, 0);
    chk(stat == '0, "R7 mode 3 no flags", stat, 0);
  endtask

  task automatic t_single();
    logic [31:0] ea [0:4];
    int          el [0:4];
    int          sum;
    fresh();
    ea = '{32'h1000, 32'h1010, 32'h1020, 32'h1030, 32'h1000};
    el = '{4, 4, 4, 3, 4};
    code = 3'd2; mode = 2'd2; dual_en = 1'b0;
    base0 = 32'h1000; ceil0 = 32'h103B;
    base1 = 32'h9000; ceil1 = 32'h90FF;
    raster_en = 1'b1;
    wait_log(6);
    for (int i = 0; i < 5; i++) begin
      chk(log_addr[i] == ea[i], "R4 address sequence", log_addr[i], ea[i]);
      chk(log_len[i] == el[i], "R2 clipped length", log_len[i], el[i]);
    end
    chk(stat[8] == 1'b1, "R4 eof0 set", stat[8], 1);
    chk(stat[9] == 1'b0, "R4 eof1 clear", stat[9], 0);
    raster_en = 1'b0;
    tick(40);
    sum = 0;
    for (int i = 0; i < log_n && i < 64; i++) sum += log_len[i];
    chk(fifo_cnt == sum, "R13 accepted bursts complete", fifo_cnt, sum);
    begin
      int n0;
      n0 = log_n;
      tick(20);
      chk(log_n == n0, "R13 no request after disable", log_n, n0);
    end
  endtask

  task automatic t_dual();
    logic [31:0] ea [0:3];
    fresh();
    ea = '{32'h2000, 32'h3000, 32'h3020, 32'h2000};
    code = 3'd3; mode = 2'd2; dual_en = 1'b1; eof_en = 1'b1;
    base0 = 32'h2000; ceil0 = 32'h201F;
    base1 = 32'h3000; ceil1 = 32'h303F;
    raster_en = 1'b1;
    wait_log(2);
    chk(stat[8] == 1'b1 && stat[9] == 1'b0, "R5 eof0 first", stat[9:8], 1);
    wait_log(4);
    for (int i = 0; i < 4; i++) begin
      chk(log_addr[i] == ea[i], "R5 alternation", log_addr[i], ea[i]);
      chk(log_len[i] == 8, "R1 burst of 8", log_len[i], 8);
    end
    chk(stat[9] == 1'b1, "R5 eof1 set", stat[9], 1);
    chk(irq == 1'b1, "R12 irq with enable", irq, 1);
    raster_en = 1'b0;
    tick(40);
    eof_en = 1'b0;
    tick(1);
    chk(irq == 1'b0, "R12 irq masked", irq, 0);
    eof_en = 1'b1;
    clr(10'h200);
    tick(1);
    chk(stat[9:8] == 2'b01, "R11 clear bit 9 only", stat[9:8], 1);
    chk(irq == 1'b1, "R12 irq on eof0 alone", irq, 1);
    clr(10'h100);
    tick(1);
    chk(stat[9:8] == 2'b00, "R11 clear bit 8", stat[9:8], 0);
    chk(irq == 1'b0, "R12 irq low no flags", irq, 0);
    dual_en = 1'b0; eof_en = 1'b0;
  endtask

  task automatic t_rebase();
    logic [31:0] ea [0:3];
    int          el [0:3];
    fresh();
    ea = '{32'h1000, 32'h1040, 32'h5000, 32'h5000};
    el = '{16, 16, 2, 2};
    code = 3'd4; mode = 2'd2; dual_en = 1'b0;
    base0 = 32'h1000; ceil0 = 32'h107F;
    raster_en = 1'b1;
    wait_log(1);
    base0 = 32'h5000; ceil0 = 32'h5007;
    wait_log(4);
    for (int i = 0; i < 4; i++) begin
      chk(log_addr[i] == ea[i], "R6 new base on next pass", log_addr[i], ea[i]);
      chk(log_len[i] == el[i], "R2 length at ceiling", log_len[i], el[i]);
    end
  endtask

  task automatic t_stall();
    fresh();
    code = 3'd0; mode = 2'd2;
    base0 = 32'h4000; ceil0 = 32'h400F;
    req_ready = 1'b0;
    raster_en = 1'b1;
    tick(3);
    chk(req == 1'b1 && req_addr == 32'h4000, "R3 request up", req_addr, 32'h4000);
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk(req == 1'b1 && req_addr == 32'h4000, "R3 request held", {req, req_addr}, {1'b1, 32'h4000});
    end
    chk(req_len == 5'd1, "R1 code 0 is one word", req_len, 1);
    req_ready = 1'b1;
    wait_log(2);
    chk(log_addr[1] == 32'h4004, "R2 advance by 4 bytes", log_addr[1], 32'h4004);
  endtask

  task automatic t_pal_data();
    int sum;
    fresh();
    code = 3'd2; mode = 2'd0;
    base0 = 32'h800; ceil0 = 32'h81F;
    raster_en = 1'b1;
    wait_log(3);
    chk(log_addr[0] == 32'h800 && log_addr[1] == 32'h810, "R7 palette range",
        log_addr[1], 32'h810);
    chk(log_addr[2] == 32'h800, "R7 data restarts at base", log_addr[2], 32'h800);
    chk(pal_cnt == 8, "R7 palette word count", pal_cnt, 8);
    chk(stat[6] == 1'b1, "R7 palette done set", stat[6], 1);
    raster_en = 1'b0;
    tick(40);
    sum = 0;
    for (int i = 2; i < log_n && i < 64; i++) sum += log_len[i];
    chk(fifo_cnt == sum, "R7 data words to fifo", fifo_cnt, sum);
    chk(pal_cnt == 8, "R7 no more palette words", pal_cnt, 8);
  endtask

  task automatic t_pal_only();
    fresh();
    code = 3'd4; mode = 2'd1;
    base0 = 32'h900; ceil0 = 32'h91F;
    raster_en = 1'b1;
    wait_log(1);
    tick(20);
    chk(log_n == 1 && log_len[0] == 8, "R8 single palette burst", log_len[0], 8);
    chk(stat[6] == 1'b1, "R8 palette done", stat[6], 1);
    chk(pal_cnt == 8 && fifo_cnt == 0, "R8 palette strobe only", fifo_cnt, 0);
    clr(10'h040);
    wait_log(2);
    chk(log_n == 2 && log_addr[1] == 32'h900, "R8 repeat after clear while on",
        log_addr[1], 32'h900);
    tick(20);
    chk(stat[6] == 1'b1, "R8 done again", stat[6], 1);
    raster_en = 1'b0;
    tick(3);
    clr(10'h040);
    tick(20);
    chk(log_n == 2, "R8 no repeat with raster off", log_n, 2);
    chk(stat[6] == 1'b0, "R8 flag stays clear", stat[6], 0);
  endtask

  task automatic t_flags();
    fresh();
    mode = 2'd3;
    raster_en = 1'b1;
    pix_rd = 1'b1; fifo_empty = 1'b1;
    tick(1);
    pix_rd = 1'b0; fifo_empty = 1'b0;
    tick(1);
    chk(stat[5] == 1'b1, "R9 underflow set", stat[5], 1);
    clr(10'h020);
    tick(1);
    chk(stat[5] == 1'b0, "R11 underflow cleared", stat[5], 0);
    pix_rd = 1'b1; fifo_empty = 1'b0;
    tick(2);
    chk(stat[5] == 1'b0, "R9 nonempty read ignored", stat[5], 0);
    raster_en = 1'b0;
    fifo_empty = 1'b1;
    tick(2);
    pix_rd = 1'b0; fifo_empty = 1'b0;
    tick(1);
    chk(stat[5] == 1'b0, "R9 ignored with raster off", stat[5], 0);
    sync_lost = 1'b1;
    stat_clr = 10'h004;
    tick(1);
    sync_lost = 1'b0;
    stat_clr = '0;
    tick(1);
    chk(stat[2] == 1'b1, "R10 sync lost set, R11 set wins", stat[2], 1);
    clr(10'h004);
    tick(1);
    chk(stat == '0, "R11 all clear", stat, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_bad_code();
    t_single();
    t_dual();
    t_rebase();
    t_stall();
    t_pal_data();
    t_pal_only();
    t_flags();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule